// File: doc/BRIEF.md
# Power-Fail Memory Enable Gate

This block sits between a host and a battery-backed static RAM. While the supply is nominal it passes the host's active-low chip-enable and write-enable straight through to the memory. When a power-fail flag from an external comparator asserts, it closes both enables so a collapsing supply cannot corrupt stored data. An access that is already under way when the failure is seen may finish. That grace period ends when the host releases the strobe or when a fixed cycle budget runs out, whichever happens first. An active-low power-fail indication is driven for as long as the failure lasts.

When power returns, the block takes one snapshot of the battery-low flags. If the batteries were never swapped during backup, only the flag of the battery that was carrying the load counts. If a swap did occur, any low battery counts. A bad result is reported to software through the memory itself: the second chip-enable cycle after power-up is swallowed whole. Software writes a location and reads it back, and a mismatch exposes the weak battery. Analog sensing, supply switching and battery selection are done outside the block.

Top module: `pf_mem_gate`

## Requirements
- R1: While the registered power-fail state is clear, `weo_no` equals `wei_ni` at all times, and `ceo_no` equals `cei_ni` unless the battery-check inhibit of R9 is active.
- R2: A clock edge that samples `pwr_fail_i` high while a strobe input is high leaves the matching output high for the whole failure, whatever that input does afterwards.
- R3: If `cei_ni` is low at the edge that first samples `pwr_fail_i` high, `ceo_no` keeps following `cei_ni` until an edge samples `cei_ni` high.
- R4: `wei_ni`/`weo_no` behave as in R3, with their own hold and timer, independent of the chip-enable path.
- R5: Counting the first-fail edge as edge 0, a held strobe is forced high from edge HOLD_CYCLES onwards, even if the host input stays low.
- R6: Once a held output has gone high during a failure, it stays high until the failure ends, even if the input falls again.
- R7: `pfo_no` is low from the edge after `pwr_fail_i` is sampled high up to the edge that samples it low again.
- R8: At the edge that first samples `pwr_fail_i` low after a failure, the battery result is latched. It is bad when `bat_swap_i`=0 and `bat_low_i[bat_sel_i]`=1, or when `bat_swap_i`=1 and any bit of `bat_low_i` is 1. Later changes of `bat_low_i`, `bat_sel_i` and `bat_swap_i` have no effect.
- R9: With a bad result, `ceo_no` is held high for the entire second chip-enable cycle after power returns. The first and third cycles pass, and `weo_no` is unaffected. Each cycle is counted on a falling edge of the synchronized `cei_ni`, so each low phase and each high phase must last at least SYNC_STAGES+1 clocks.
- R10: With a good result, every chip-enable cycle after power returns passes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_fail_i | input | 1 | Supply out of tolerance, from comparator |
| bat_low_i | input | NUM_BAT | Per-battery low flag |
| bat_sel_i | input | $clog2(NUM_BAT) | Battery carrying the backup load |
| bat_swap_i | input | 1 | A battery swap happened during backup |
| cei_ni | input | 1 | Host chip enable, active low |
| wei_ni | input | 1 | Host write enable, active low |
| ceo_no | output | 1 | Memory chip enable, active low |
| weo_no | output | 1 | Memory write enable, active low |
| pfo_no | output | 1 | Power-fail indication, active low |

## Verification
The bench sweeps the cycle at which the host releases each strobe against the hold budget, including a release that never comes before the timeout. It also pulls the strobe low again after release. A design with an off-by-one timer would cut the access a cycle early or late, and one that re-samples the input would let a late write reach the memory. All sixteen battery-flag combinations are then driven, and the flags are inverted after power-up. A design that ignored the swap flag, read the wrong battery or kept sampling the flags would swallow the wrong cycle, chop the first or third cycle, or gate the write enable.

// File: rtl/pf_gate_pkg.sv
package pf_gate_pkg;
  typedef enum logic [2:0] {
    CHK_IDLE,
    CHK_WAIT_FALL1,
    CHK_WAIT_RISE1,
    CHK_WAIT_FALL2,
    CHK_WAIT_RISE2
  } chk_state_e;
endpackage

// File: rtl/pf_in_sync.sv
module pf_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_ni,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], in_ni};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];
  assign rise_o = ~last_q & sync_q[STAGES-1];
endmodule

// File: rtl/pf_hold_ch.sv
module pf_hold_ch #(
  parameter int unsigned HOLD_CYCLES = 75
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_rise_i,
  input  logic fail_q_i,
  input  logic in_ni,
  output logic gated_no
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

  logic          hold_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (fail_rise_i) begin
      hold_q <= ~in_ni;
      cnt_q  <= CW'(1);
    end else if (!fail_q_i) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (hold_q) begin
      // release on strobe end or budget exhausted
      if (in_ni || cnt_q == CW'(HOLD_CYCLES)) hold_q <= 1'b0;
      else                                    cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign gated_no = hold_q ? in_ni : 1'b1;
endmodule

// File: rtl/pf_batt_check.sv
module pf_batt_check
  import pf_gate_pkg::*;
#(
  parameter int unsigned NUM_BAT = 2,
  localparam int unsigned SEL_W = $clog2(NUM_BAT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fail_fall_i,
  input  logic               fail_q_i,
  input  logic [NUM_BAT-1:0] bat_low_i,
  input  logic [SEL_W-1:0]   bat_sel_i,
  input  logic               bat_swap_i,
  input  logic               ce_fall_i,
  input  logic               ce_rise_i,
  output logic               inhibit_o
);
  chk_state_e state_q;
  logic       bad_q;
  logic       bad_now;

  assign bad_now = bat_swap_i ? |bat_low_i : bat_low_i[bat_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CHK_IDLE;
      bad_q   <= 1'b0;
    end else if (fail_fall_i) begin
      state_q <= CHK_WAIT_FALL1;
      bad_q   <= bad_now;
    end else if (fail_q_i) begin
      state_q <= CHK_IDLE;
    end else begin
      unique case (state_q)
        CHK_WAIT_FALL1: if (ce_fall_i) state_q <= CHK_WAIT_RISE1;
        CHK_WAIT_RISE1: if (ce_rise_i) state_q <= CHK_WAIT_FALL2;
        CHK_WAIT_FALL2: if (ce_fall_i) state_q <= CHK_WAIT_RISE2;
        CHK_WAIT_RISE2: if (ce_rise_i) state_q <= CHK_IDLE;
        default:        state_q <= CHK_IDLE;
      endcase
    end
  end

  // armed between end of cycle 1 and end of cycle 2
  assign inhibit_o = bad_q &
                     (state_q == CHK_WAIT_FALL2 || state_q == CHK_WAIT_RISE2);
endmodule

// File: rtl/pf_mem_gate.sv
module pf_mem_gate #(
  parameter int unsigned HOLD_CYCLES = 75,
  parameter int unsigned NUM_BAT     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = $clog2(NUM_BAT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwr_fail_i,
  input  logic [NUM_BAT-1:0] bat_low_i,
  input  logic [SEL_W-1:0]   bat_sel_i,
  input  logic               bat_swap_i,
  input  logic               cei_ni,
  input  logic               wei_ni,
  output logic               ceo_no,
  output logic               weo_no,
  output logic               pfo_no
);
  localparam int unsigned NCH = 2;

  logic           fail_q;
  logic           fail_rise;
  logic           fail_fall;
  logic [NCH-1:0] strobe_n;
  logic [NCH-1:0] held_n;
  logic           ce_fall;
  logic           ce_rise;
  logic           inhibit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fail_q <= 1'b0;
    else         fail_q <= pwr_fail_i;
  end

  assign fail_rise = pwr_fail_i & ~fail_q;
  assign fail_fall = ~pwr_fail_i & fail_q;
  assign strobe_n  = {wei_ni, cei_ni};

  for (genvar g = 0; g < NCH; g++) begin : g_hold
    pf_hold_ch #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fail_rise_i(fail_rise),
      .fail_q_i   (fail_q),
      .in_ni      (strobe_n[g]),
      .gated_no   (held_n[g])
    );
  end

  pf_in_sync #(.STAGES(SYNC_STAGES)) u_ce_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_ni (cei_ni),
    .fall_o(ce_fall),
    .rise_o(ce_rise)
  );

  pf_batt_check #(.NUM_BAT(NUM_BAT)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fail_fall_i(fail_fall),
    .fail_q_i   (fail_q),
    .bat_low_i  (bat_low_i),
    .bat_sel_i  (bat_sel_i),
    .bat_swap_i (bat_swap_i),
    .ce_fall_i  (ce_fall),
    .ce_rise_i  (ce_rise),
    .inhibit_o  (inhibit)
  );

  assign ceo_no = fail_q ? held_n[0] : (cei_ni | inhibit);
  assign weo_no = fail_q ? held_n[1] : wei_ni;
  assign pfo_no = ~fail_q;
endmodule

// File: rtl/pf_mem_gate_chk.sv
module pf_mem_gate_chk #(
  parameter int unsigned HOLD_CYCLES = 75
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_fail_i,
  input logic cei_ni,
  input logic wei_ni,
  input logic ceo_no,
  input logic weo_no,
  input logic pfo_no
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 2);
  logic [CW-1:0] fail_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            fail_cnt_q <= '0;
    else if (pfo_no)                        fail_cnt_q <= '0;
    else if (fail_cnt_q < CW'(HOLD_CYCLES)) fail_cnt_q <= fail_cnt_q + CW'(1);
  end

  AST_WE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfo_no |-> (weo_no == wei_ni)); // R1
  AST_CE_IDLE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pfo_no && cei_ni) |-> ceo_no); // R3
  AST_CE_STAY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_fail_i && !pfo_no && ceo_no) |=> ceo_no); // R6
  AST_WE_STAY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_fail_i && !pfo_no && weo_no) |=> weo_no); // R4
  AST_HOLD_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pfo_no && fail_cnt_q >= CW'(HOLD_CYCLES)) |-> (ceo_no && weo_no)); // R5
  AST_PFO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> !pfo_no); // R7
  AST_PFO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_fail_i |=> pfo_no); // R7
endmodule

bind pf_mem_gate pf_mem_gate_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_pf_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_fail_i(pwr_fail_i),
  .cei_ni    (cei_ni),
  .wei_ni    (wei_ni),
  .ceo_no    (ceo_no),
  .weo_no    (weo_no),
  .pfo_no    (pfo_no)
);

// File: tb/pf_mem_gate_test.sv
module pf_mem_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwr_fail_i = 1'b0;
  logic [1:0] bat_low_i = 2'b00;
  logic       bat_sel_i = 1'b0;
  logic       bat_swap_i = 1'b0;
  logic       cei_ni = 1'b1;
  logic       wei_ni = 1'b1;
  logic       ceo_no, weo_no, pfo_no;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  pf_mem_gate #(.HOLD_CYCLES(HOLD), .NUM_BAT(2), .SYNC_STAGES(2)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_fail_i(pwr_fail_i),
    .bat_low_i(bat_low_i), .bat_sel_i(bat_sel_i), .bat_swap_i(bat_swap_i),
    .cei_ni(cei_ni), .wei_ni(wei_ni),
    .ceo_no(ceo_no), .weo_no(weo_no), .pfo_no(pfo_no)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    chk("reset ceo", ceo_no, 1'b1);
    chk("reset weo", weo_no, 1'b1);
    chk("R7 reset pfo", pfo_no, 1'b1);

    // R1: nominal pass-through, all strobe combinations
    for (int v = 0; v < 4; v++) begin
      cei_ni = v[0]; wei_ni = v[1];
      #1;
      chk("R1 ceo", ceo_no, v[0]);
      chk("R1 weo", weo_no, v[1]);
      tick();
    end
    cei_ni = 1; wei_ni = 1; tick();

    // R2: fail with no access in progress
    pwr_fail_i = 1; tick();
    chk("R7 pfo low", pfo_no, 1'b0);
    for (int k = 0; k < 3; k++) begin
      cei_ni = k[0]; wei_ni = ~k[0];
      #1;
      chk("R2 ceo blocked", ceo_no, 1'b1);
      chk("R2 weo blocked", weo_no, 1'b1);
      tick();
    end
    pwr_fail_i = 0; cei_ni = 1; wei_ni = 1; tick();
    chk("R7 pfo released", pfo_no, 1'b1);

    // R3/R4/R5/R6: release index swept against the hold budget
    for (int r = 1; r <= HOLD + 1; r++) begin
      int rw;
      rw = HOLD + 2 - r;
      pwr_fail_i = 0; cei_ni = 1; wei_ni = 1;
      tick(); tick(); tick();
      cei_ni = 0; wei_ni = 0;
      #1;
      chk("R1 access start ce", ceo_no, 1'b0);
      tick();
      pwr_fail_i = 1;
      tick();
      for (int j = 0; j <= HOLD + 2; j++) begin
        cei_ni = (j == r)  ? 1'b1 : 1'b0;
        wei_ni = (j == rw) ? 1'b1 : 1'b0;
        #1;
        // R5 timeout at j>=HOLD, R6 no reopening after release
        chk("R3 R5 R6 ceo hold", ceo_no, (j < HOLD && j < r)  ? 1'b0 : 1'b1);
        chk("R4 R5 R6 weo hold", weo_no, (j < HOLD && j < rw) ? 1'b0 : 1'b1);
        chk("R7 pfo during fail", pfo_no, 1'b0);
        tick();
      end
      pwr_fail_i = 0; cei_ni = 1; wei_ni = 1;
      tick();
      chk("R7 pfo after fail", pfo_no, 1'b1);
    end

    // R8/R9/R10: every battery flag combination
    for (int m = 0; m < 16; m++) begin
      logic [1:0] low;
      logic       sel, swp, bad;
      low = m[1:0]; sel = m[2]; swp = m[3];
      bad = swp ? (low[0] | low[1]) : low[sel];
      cei_ni = 1; wei_ni = 1;
      pwr_fail_i = 1; tick(); tick();
      bat_low_i = low; bat_sel_i = sel; bat_swap_i = swp;
      pwr_fail_i = 0;
      tick();
      // R8: flags changed after the snapshot must not matter
      bat_low_i = ~low; bat_sel_i = ~sel; bat_swap_i = ~swp;
      tick(); tick();
      for (int c = 0; c < 3; c++) begin
        cei_ni = 0; wei_ni = 0;
        for (int s = 0; s < 4; s++) begin
          #1;
          if (bad) chk("R8 R9 ceo cycle", ceo_no, (c == 1) ? 1'b1 : 1'b0);
          else     chk("R8 R10 ceo cycle", ceo_no, 1'b0);
          chk("R9 weo untouched", weo_no, 1'b0);
          tick();
        end
        cei_ni = 1; wei_ni = 1;
        for (int s = 0; s < 5; s++) tick();
        chk("R9 ceo idle", ceo_no, 1'b1);
      end
      bat_low_i = 0; bat_sel_i = 0; bat_swap_i = 0;
    end

    finish_run();
  end
endmodule